// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the sequence of element addresses for one DMA channel. Software loads a base address, an element count and signed stride for the inner loop, an element count and signed stride for the outer loop, an element width and a few mode flags. A start strobe then launches a pass. The data mover takes addresses one at a time through a valid/advance handshake. In one-dimensional mode only the inner loop runs. In two-dimensional mode the outer stride joins rows together. Because the outer stride may be smaller than, or opposite in sign to, the inner stride, the block can walk an interleaved buffer one stream at a time.

The block is built around a three-state controller. `S_IDLE` is the state after reset. `S_RUN` presents addresses. `S_DONE` is the state after a single pass in stop mode. The transitions are: `start` (from `S_IDLE` or `S_DONE` to `S_RUN`, latching the configuration), `pass_end_stop` (last element accepted in stop mode, `S_RUN` to `S_DONE`) and `pass_end_wrap` (last element accepted in circular mode, `S_RUN` to `S_RUN` with the base address and counts reloaded). An interrupt pulse marks each pass end and, if requested, each row end.

Top module: `dma2d_agen`

## Requirements
- R1: After reset `addr_valid`, `done` and `irq` are all 0.
- R2: A `start` pulse in `S_IDLE` or `S_DONE` latches the configuration. The next cycle `addr_valid` is 1 and `addr` equals the base address. A `start` during `S_RUN` is ignored, and the running sequence continues unchanged.
- R3: In 1-D mode (`cfg_two_d`=0) the k-th address of a pass is base + k·inner_stride·size, for k = 0 … inner_count−1.
- R4: In 2-D mode the address after the last element of a row is the current address plus outer_stride·size, instead of inner_stride·size. A pass covers outer_count rows. Strides are two's-complement, so negative strides, and an outer stride smaller than the inner stride, are both valid.
- R5: A count field of 0 means 65536 elements.
- R6: `cfg_elem_size` scales both strides: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 4 bytes.
- R7: The address moves on only in a cycle where both `addr_valid` and `adv` are 1. Otherwise `addr` holds.
- R8: In stop mode (`cfg_circular`=0), the cycle after the last element of a pass is accepted, `addr_valid` is 0 and `done` is 1. `done` stays 1 until the next `start`.
- R9: In circular mode, the cycle after the last element is accepted, `addr` is back at the base address with `addr_valid`=1. The pass repeats and `done` stays 0.
- R10: `irq` is a one-cycle pulse in the cycle after the last element of each pass is accepted. With `cfg_row_irq`=1 in 2-D mode, it also pulses after the last element of every row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Base address of the pass |
| cfg_inner_cnt | input | CW | Elements per row (0 = 65536) |
| cfg_inner_stride | input | SW | Signed step between elements of a row, in elements |
| cfg_outer_cnt | input | CW | Rows per pass (0 = 65536), 2-D only |
| cfg_outer_stride | input | SW | Signed step from the last element of a row to the next row, in elements |
| cfg_two_d | input | 1 | 1 = 2-D mode |
| cfg_circular | input | 1 | 1 = circular reload, 0 = stop after one pass |
| cfg_row_irq | input | 1 | 1 = interrupt at every row end in 2-D mode |
| cfg_elem_size | input | 2 | Element width code |
| start | input | 1 | Launch strobe |
| adv | input | 1 | Data mover consumes the current address |
| addr | output | AW | Current element address |
| addr_valid | output | 1 | `addr` is valid |
| irq | output | 1 | Interrupt pulse |
| done | output | 1 | Stop-mode pass completed |

## Verification
The assertions check, on every cycle, the local rules. `addr_valid` and `done` are never high together. A stalled address holds. Every `irq` pulse and every rise of `done` follows an accepted element. `done` persists until a new start. Only the bench scenarios can show the arithmetic of the address sequence: the stride choice at row boundaries, element-size scaling, the 65536 encoding of a zero count, the reload in circular mode, and which advances raise an interrupt. The bench sweeps small counts, signed strides, sizes, modes and stall patterns against addresses it computes itself.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } agen_state_t;

    // Left shift that turns an element step into a byte step.
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        logic [1:0] sh;
        unique case (code)
            2'd0:    sh = 2'd0;
            2'd1:    sh = 2'd1;
            default: sh = 2'd2;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/dma2d_cnt.sv
// Down counter holding (elements remaining - 1); a zero field loads all ones.
module dma2d_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val - W'(1);
        end else if (dec) begin
            rem_q <= rem_q - W'(1);
        end
    end

    assign last = (rem_q == '0);
endmodule

// File: rtl/dma2d_addr.sv
// Address accumulator: loads the base, or adds a scaled, sign-extended stride.
module dma2d_addr
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          use_outer,
    input  logic [SW-1:0] inner_stride,
    input  logic [SW-1:0] outer_stride,
    input  logic [1:0]    elem_size,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - SW;

    logic [SW-1:0] stride_sel;
    logic [AW-1:0] stride_ext;
    logic [AW-1:0] stride_bytes;
    logic [AW-1:0] addr_q;

    always_comb begin
        stride_sel   = use_outer ? outer_stride : inner_stride;
        stride_ext   = {{EXT{stride_sel[SW-1]}}, stride_sel};
        stride_bytes = stride_ext << size_shift(elem_size);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (step) begin
            addr_q <= addr_q + stride_bytes;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_inner_cnt,
    input  logic [SW-1:0] cfg_inner_stride,
    input  logic [CW-1:0] cfg_outer_cnt,
    input  logic [SW-1:0] cfg_outer_stride,
    input  logic          cfg_two_d,
    input  logic          cfg_circular,
    input  logic          cfg_row_irq,
    input  logic [1:0]    cfg_elem_size,
    input  logic          start,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          addr_valid,
    output logic          irq,
    output logic          done
);
    agen_state_t st_q, st_d;

    // Latched configuration, captured on an accepted start.
    logic [AW-1:0] base_q;
    logic [CW-1:0] icnt_q, ocnt_q;
    logic [SW-1:0] istr_q, ostr_q;
    logic          two_d_q, circ_q, row_irq_q;
    logic [1:0]    esz_q;

    logic start_acc, fire, in_last, out_last, row_end, pass_end;
    logic in_load, out_load, in_dec, out_dec;
    logic [CW-1:0] in_ld_val, out_ld_val;
    logic addr_load, addr_step;
    logic [AW-1:0] addr_ld_val;
    logic irq_q;

    assign start_acc = start && (st_q != S_RUN);
    assign fire      = (st_q == S_RUN) && adv;
    assign row_end   = fire && in_last;
    assign pass_end  = row_end && (!two_d_q || out_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            icnt_q    <= '0;
            ocnt_q    <= '0;
            istr_q    <= '0;
            ostr_q    <= '0;
            two_d_q   <= 1'b0;
            circ_q    <= 1'b0;
            row_irq_q <= 1'b0;
            esz_q     <= '0;
        end else if (start_acc) begin
            base_q    <= cfg_base;
            icnt_q    <= cfg_inner_cnt;
            ocnt_q    <= cfg_outer_cnt;
            istr_q    <= cfg_inner_stride;
            ostr_q    <= cfg_outer_stride;
            two_d_q   <= cfg_two_d;
            circ_q    <= cfg_circular;
            row_irq_q <= cfg_row_irq;
            esz_q     <= cfg_elem_size;
        end
    end

    // Loop counters.
    assign in_load    = start_acc || row_end;
    assign in_ld_val  = start_acc ? cfg_inner_cnt : icnt_q;
    assign in_dec     = fire && !in_last;
    assign out_load   = start_acc || pass_end;
    assign out_ld_val = start_acc ? cfg_outer_cnt : ocnt_q;
    assign out_dec    = row_end && two_d_q && !out_last;

    dma2d_cnt #(.W(CW)) u_inner (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_load),
        .load_val (in_ld_val),
        .dec      (in_dec),
        .last     (in_last)
    );

    dma2d_cnt #(.W(CW)) u_outer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (out_load),
        .load_val (out_ld_val),
        .dec      (out_dec),
        .last     (out_last)
    );

    // Address path.
    assign addr_load   = start_acc || (pass_end && circ_q);
    assign addr_ld_val = start_acc ? cfg_base : base_q;
    assign addr_step   = fire && !pass_end;

    dma2d_addr #(.AW(AW), .SW(SW)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (addr_load),
        .load_addr    (addr_ld_val),
        .step         (addr_step),
        .use_outer    (in_last && two_d_q),
        .inner_stride (istr_q),
        .outer_stride (ostr_q),
        .elem_size    (esz_q),
        .addr         (addr)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (start) st_d = S_RUN;
            S_RUN:  if (pass_end && !circ_q) st_d = S_DONE;
            S_DONE: if (start) st_d = S_RUN;
            default: st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Interrupt pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pass_end || (row_end && two_d_q && row_irq_q);
    end

    // Outputs.
    always_comb begin
        addr_valid = (st_q == S_RUN);
        done       = (st_q == S_DONE);
        irq        = irq_q;
    end
endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          adv,
    input logic [AW-1:0] addr,
    input logic          addr_valid,
    input logic          irq,
    input logic          done
);
    a_r8_valid_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && done));

    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !adv) |=> (addr_valid && $stable(addr)));

    a_r10_irq_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(addr_valid && adv));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r8_done_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(addr_valid && adv));
endmodule

bind dma2d_agen dma2d_agen_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .adv        (adv),
    .addr       (addr),
    .addr_valid (addr_valid),
    .irq        (irq),
    .done       (done)
);

// File: tb/dma2d_agen_bench.sv
module dma2d_agen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_inner_cnt = '0, cfg_inner_stride = '0;
    logic [15:0] cfg_outer_cnt = '0, cfg_outer_stride = '0;
    logic        cfg_two_d = 1'b0, cfg_circular = 1'b0, cfg_row_irq = 1'b0;
    logic [1:0]  cfg_elem_size = '0;
    logic        start = 1'b0, adv = 1'b0;
    logic [31:0] addr;
    logic        addr_valid, irq, done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dma2d_agen u_dma2d_agen (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
        .cfg_inner_cnt(cfg_inner_cnt), .cfg_inner_stride(cfg_inner_stride),
        .cfg_outer_cnt(cfg_outer_cnt), .cfg_outer_stride(cfg_outer_stride),
        .cfg_two_d(cfg_two_d), .cfg_circular(cfg_circular),
        .cfg_row_irq(cfg_row_irq), .cfg_elem_size(cfg_elem_size),
        .start(start), .adv(adv), .addr(addr), .addr_valid(addr_valid),
        .irq(irq), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish (actual=%0d expected<150000)", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; adv = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_cfg(input longint base, input int ic, input int istr,
                           input int oc, input int ostr, input bit twod,
                           input bit circ, input bit rirq, input int esz,
                           input int passes, input bit stall);
        int ie = (ic == 0) ? 65536 : ic;
        int oe = twod ? ((oc == 0) ? 65536 : oc) : 1;
        int eb = (esz == 0) ? 1 : (esz == 1) ? 2 : 4;
        int cyc = 0;
        string tag = (esz != 0) ? "R6" : (twod ? "R4" : "R3");
        cfg_base = base[31:0];
        cfg_inner_cnt = ic[15:0];
        cfg_inner_stride = istr[15:0];
        cfg_outer_cnt = oc[15:0];
        cfg_outer_stride = ostr[15:0];
        cfg_two_d = twod; cfg_circular = circ; cfg_row_irq = rirq;
        cfg_elem_size = esz[1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < passes; p++) begin
            for (int o = 0; o < oe; o++) begin
                for (int i = 0; i < ie; i++) begin
                    longint ex = (base + (longint'(o) * (ostr + (ie - 1) * istr)
                                 + longint'(i) * istr) * eb) & 64'hFFFF_FFFF;
                    bit exp_irq = ((i == ie - 1) && (o == oe - 1)) ||
                                  (rirq && twod && (i == ie - 1));
                    bit acc = 1'b0;
                    while (!acc) begin
                        chk(addr_valid === 1'b1 && addr === ex[31:0], tag, longint'(addr), ex);
                        adv = stall ? ((cyc % 3) != 2) : 1'b1;
                        cyc++;
                        @(negedge clk);
                        if (adv) begin
                            chk(irq === exp_irq, "R10", longint'(irq), longint'(exp_irq));
                            acc = 1'b1;
                        end else begin
                            chk(irq === 1'b0, "R7", longint'(irq), 0);
                        end
                    end
                end
            end
        end
        adv = 1'b0;
        if (!circ) begin
            chk(addr_valid === 1'b0 && done === 1'b1, "R8",
                longint'({addr_valid, done}), 64'h1);
            repeat (2) @(negedge clk);
            chk(done === 1'b1, "R8", longint'(done), 1);
        end else begin
            chk(addr_valid === 1'b1 && addr === base[31:0] && done === 1'b0, "R9",
                longint'(addr), base);
            do_reset();
        end
    endtask

    initial begin
        int n;
        do_reset();
        // R1: outputs idle after reset
        chk(addr_valid === 1'b0 && done === 1'b0 && irq === 1'b0, "R1",
            longint'({addr_valid, done, irq}), 0);

        // Sweep: R3, R4, R6, R7, R8, R10
        for (int twod = 0; twod < 2; twod++)
            for (int ic = 1; ic <= 3; ic++)
                for (int oc = 1; oc <= 3; oc++)
                    for (int esz = 0; esz < 4; esz++)
                        for (int sv = 0; sv < 2; sv++) begin
                            int is_ = (sv == 0) ? 2 : -3;
                            int os_ = (sv == 0) ? 1 - 2 * ic : 7;
                            run_cfg(64'h1000 + 64'(esz * 16), ic, is_, oc, os_,
                                    twod[0], 1'b0, esz[0], esz, 1, sv[0] ^ esz[1]);
                        end

        // R4: de-interleave, outer stride below inner stride, three streams
        run_cfg(64'h200, 4, 3, 3, -8, 1'b1, 1'b0, 1'b1, 1, 1, 1'b0);
        // R4: wrap past address zero with negative strides
        run_cfg(64'h4, 3, -1, 2, -5, 1'b1, 1'b0, 1'b0, 2, 1, 1'b1);

        // R9: circular, several passes, row interrupts
        run_cfg(64'h8000, 2, 4, 3, -1, 1'b1, 1'b1, 1'b1, 1, 3, 1'b1);
        run_cfg(64'h9000, 3, 1, 1, 0, 1'b0, 1'b1, 1'b0, 0, 4, 1'b0);

        // R2: start while running is ignored
        cfg_base = 32'h3000; cfg_inner_cnt = 16'd4; cfg_inner_stride = 16'd1;
        cfg_outer_cnt = 16'd1; cfg_outer_stride = 16'd0; cfg_two_d = 1'b0;
        cfg_circular = 1'b0; cfg_row_irq = 1'b0; cfg_elem_size = 2'd0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(addr_valid === 1'b1 && addr === 32'h3000, "R2", longint'(addr), 64'h3000);
        adv = 1'b1; @(negedge clk); adv = 1'b0;
        cfg_base = 32'h7777; start = 1'b1; @(negedge clk); start = 1'b0;
        chk(addr === 32'h3001 && addr_valid === 1'b1, "R2", longint'(addr), 64'h3001);
        adv = 1'b1; repeat (3) @(negedge clk); adv = 1'b0;
        chk(done === 1'b1, "R2", longint'(done), 1);

        // R5: zero count field means 65536 elements
        cfg_base = 32'h10000; cfg_inner_cnt = 16'd0; cfg_inner_stride = 16'd1;
        cfg_circular = 1'b0; cfg_two_d = 1'b0; cfg_elem_size = 2'd0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        n = 0;
        adv = 1'b1;
        while (addr_valid === 1'b1 && n < 70000) begin
            if (n == 65535)
                chk(addr === 32'h1FFFF, "R5", longint'(addr), 64'h1FFFF);
            n++;
            @(negedge clk);
        end
        adv = 1'b0;
        chk(n == 65536, "R5", n, 65536);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule